// File: doc/BRIEF.md
# I2C Master Byte Transfer Engine

This block is the master half of a byte-level I2C engine. Software-style control inputs ask it to place a start condition on the bus, to move one data unit out to or in from a slave, or to end the bus transaction with a stop condition. Each data unit is 1 to 8 bits long, shifted most significant bit first. An optional ninth clock pulse carries the acknowledge. On a write the engine releases SDA for that pulse and reads the slave's answer. On a read it pulls SDA low to acknowledge the slave.

SCL is made from the system clock with an asymmetric waveform. A 3-bit rate code picks an exponent n. SCL then stays low for 2^(n-1) system clocks and high for 8 system clocks more than that. Both bus lines are open-drain outputs, so the block only ever drives a line low or releases it. SDA is read back from the pad for received data and for acknowledge bits.

A 3-bit bit-count setting is written through a write strobe and keeps its value across transfers. Every start condition clears it, so the address byte that follows a start always goes out as a full 8 bits. When a unit has been moved, a one-cycle done pulse marks the end and the acknowledge status is updated.

Top module: `i2c_byte_master`

## Requirements
- R1: While reset is held, and after it is released, SCL and SDA are both released (`scl_oe_o` = 0, `sda_oe_o` = 0), `busy_o` = 0, `done_o` = 0, `ack_o` = 1 and `bit_cnt_o` = 000.
- R2: The rate code c gives the exponent n = c + 5 for c from 0 to 6, and code 7 gives n = 11. During a transfer, each full SCL low period lasts 2^(n-1) system clocks and each SCL high period lasts 2^(n-1) + 8 system clocks. The code is captured when a command is accepted.
- R3: A write moves k bits, where bit-count code 000 means k = 8 and codes 001 to 111 mean k = 1 to 7. The bits are `tx_data_i[7]` down to `tx_data_i[8-k]`, in that order, one per SCL pulse. During a transfer SDA never changes while SCL is high.
- R4: On a write with acknowledge enabled, one extra SCL pulse follows the data bits and the engine releases SDA for it. The SDA level sampled in the middle of that high phase is latched into `ack_o`, where 0 means acknowledged.
- R5: On a read, SDA is released for the k data bits and sampled in the middle of each SCL high phase. Each sample is shifted in at bit 0, so `rx_data_o` holds the k received bits with the first bit received at position k-1 and zeros above. With acknowledge enabled, the engine drives SDA low for the extra pulse, and `ack_o` then reads 0.
- R6: With acknowledge disabled, exactly k SCL pulses occur and `ack_o` is set to 1 at the end of the transfer.
- R7: A start condition is SDA falling while SCL is high, after which SCL is held low. It is accepted from both the idle bus and a held bus (repeated start), and it clears the bit-count setting to 000. Otherwise the setting keeps the last value written with `bc_we_i`.
- R8: A stop condition is SDA rising while SCL is high. Afterwards both lines stay released and `busy_o` is 0.
- R9: Each accepted write or read ends with `done_o` high for exactly one cycle, and no done pulse occurs at any other time.
- R10: Strobes that arrive while `busy_o` is 1 are ignored. Write, read and stop strobes on an idle bus (no start since the last stop) are ignored and produce no SCL pulse. When several strobes arrive together, start wins over stop, stop over write, and write over read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ack_en_i | input | 1 | 1 adds an acknowledge clock pulse to each transfer |
| clk_sel_i | input | 3 | SCL rate code |
| bc_we_i | input | 1 | Write strobe for the bit-count setting |
| bc_wdata_i | input | 3 | New bit-count code (000 = 8 bits) |
| start_i | input | 1 | Start condition request |
| stop_i | input | 1 | Stop condition request |
| wr_i | input | 1 | Write transfer request |
| rd_i | input | 1 | Read transfer request |
| tx_data_i | input | 8 | Data to send, left aligned |
| sda_i | input | 1 | SDA pad level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | A start, stop or transfer is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |
| ack_o | output | 1 | Latched acknowledge status (0 = acknowledged) |
| rx_data_o | output | 8 | Received bits, right aligned |
| bit_cnt_o | output | 3 | Current bit-count setting |

## Verification
The engine is exercised with writes of alternating, left-aligned and single-bit patterns, with bit counts of 8, 3 and 1, and with a slave model that answers with both an acknowledge and a no-acknowledge, so that bit order, bit count and acknowledge latching are each checked separately. Reads of 8 and 4 bits, with the acknowledge pulse on and off, show that the master's own acknowledge drive and the zero-extension of short units both work. SCL low and high times are measured on the bus line at rate codes 0, 2 and 7, which separates the exponent map, the fixed 8-clock extension and the treatment of the reserved code. Strobes sent during a busy transfer and on an idle bus, together with repeated start and stop, check that these commands are ignored or honoured as required and that the bit-count setting is cleared or kept as required.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_START,
    ST_STOP,
    ST_XFER
  } bus_state_t;

  typedef enum logic [1:0] {
    PH_LOW,
    PH_HIGH,
    PH_HIGH2
  } phase_t;

endpackage

// File: rtl/i2c_rst_sync.sv
module i2c_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/i2c_rate_decode.sv
module i2c_rate_decode #(
  parameter int SEL_W      = 3,
  parameter int BASE_EXP   = 5,
  parameter int TOP_CODE   = 6,
  parameter int HIGH_EXTRA = 8,
  parameter int CNT_W      = 11
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0] low_len_o,
  output logic [CNT_W-1:0] high_len_o
);

  logic [SEL_W-1:0] code;
  logic [CNT_W-1:0] shamt;

  // codes above the top legal value behave as the top value
  assign code       = (sel_i > SEL_W'(TOP_CODE)) ? SEL_W'(TOP_CODE) : sel_i;
  assign shamt      = CNT_W'(BASE_EXP - 1) + CNT_W'(code);
  assign low_len_o  = CNT_W'(1) << shamt;
  assign high_len_o = low_len_o + CNT_W'(HIGH_EXTRA);

endmodule

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign last_o = run_i && (cnt_q == len_i - CNT_W'(1));

  always_comb begin
    if (!run_i || last_o) cnt_d = '0;
    else                  cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R2: a phase never outlasts its programmed length
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < len_i));

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_eng_pkg::*;
#(
  parameter int SEL_W       = 3,
  parameter int BC_W        = 3,
  parameter int BASE_EXP    = 5,
  parameter int TOP_CODE    = 6,
  parameter int HIGH_EXTRA  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ack_en_i,
  input  logic [SEL_W-1:0]      clk_sel_i,
  input  logic                  bc_we_i,
  input  logic [BC_W-1:0]       bc_wdata_i,
  input  logic                  start_i,
  input  logic                  stop_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [(1<<BC_W)-1:0]  tx_data_i,
  input  logic                  sda_i,
  output logic                  scl_oe_o,
  output logic                  sda_oe_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  ack_o,
  output logic [(1<<BC_W)-1:0]  rx_data_o,
  output logic [BC_W-1:0]       bit_cnt_o
);

  localparam int DATA_W = 1 << BC_W;
  localparam int CNT_W  = BASE_EXP + TOP_CODE;
  localparam int LEFT_W = BC_W + 1;

  logic rst_sync_n;

  i2c_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  // state
  bus_state_t         state_q, state_d;
  phase_t             phase_q, phase_d;
  logic               scl_rel_q, scl_rel_d;
  logic               sda_rel_q, sda_rel_d;
  logic [DATA_W-1:0]  shift_q, shift_d;
  logic [DATA_W-1:0]  rx_q, rx_d;
  logic [LEFT_W-1:0]  left_q, left_d;
  logic               ack_stage_q, ack_stage_d;
  logic               is_rd_q, is_rd_d;
  logic               ack_en_q, ack_en_d;
  logic [SEL_W-1:0]   sel_q, sel_d;
  logic [BC_W-1:0]    bc_q, bc_d;
  logic               ack_q, ack_d;
  logic               done_q, done_d;

  // rate and phase timing
  logic [CNT_W-1:0] low_len, high_len, tmr_len, tmr_cnt, mid_cnt;
  logic             tmr_last, run;

  i2c_rate_decode #(
    .SEL_W(SEL_W), .BASE_EXP(BASE_EXP), .TOP_CODE(TOP_CODE),
    .HIGH_EXTRA(HIGH_EXTRA), .CNT_W(CNT_W)
  ) u_rate (
    .sel_i      (sel_q),
    .low_len_o  (low_len),
    .high_len_o (high_len)
  );

  assign run     = (state_q == ST_START) || (state_q == ST_STOP) || (state_q == ST_XFER);
  assign tmr_len = (phase_q == PH_LOW) ? low_len : high_len;
  assign mid_cnt = high_len >> 1;

  i2c_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run_i  (run),
    .len_i  (tmr_len),
    .cnt_o  (tmr_cnt),
    .last_o (tmr_last)
  );

  // command acceptance with fixed priority
  logic bus_free, acc_start, acc_stop, acc_wr, acc_rd;
  assign bus_free  = (state_q == ST_IDLE) || (state_q == ST_HOLD);
  assign acc_start = start_i && bus_free;
  assign acc_stop  = !start_i && stop_i && (state_q == ST_HOLD);
  assign acc_wr    = !start_i && !stop_i && wr_i && (state_q == ST_HOLD);
  assign acc_rd    = !start_i && !stop_i && !wr_i && rd_i && (state_q == ST_HOLD);

  // SDA level wanted during the low phase of the current step
  logic low_sda;
  always_comb begin
    unique case (state_q)
      ST_START: low_sda = 1'b1;
      ST_STOP:  low_sda = 1'b0;
      ST_XFER:  low_sda = ack_stage_q ? !is_rd_q : (is_rd_q || shift_q[DATA_W-1]);
      default:  low_sda = sda_rel_q;
    endcase
  end

  // next-state logic
  always_comb begin
    state_d     = state_q;
    phase_d     = phase_q;
    scl_rel_d   = scl_rel_q;
    sda_rel_d   = sda_rel_q;
    shift_d     = shift_q;
    rx_d        = rx_q;
    left_d      = left_q;
    ack_stage_d = ack_stage_q;
    is_rd_d     = is_rd_q;
    ack_en_d    = ack_en_q;
    sel_d       = sel_q;
    bc_d        = bc_q;
    ack_d       = ack_q;
    done_d      = 1'b0;

    if (bc_we_i)   bc_d = bc_wdata_i;
    if (acc_start) bc_d = '0;

    unique case (state_q)
      ST_IDLE, ST_HOLD: begin
        if (acc_start) begin
          state_d   = ST_START;
          phase_d   = PH_LOW;
          scl_rel_d = 1'b0;
          sel_d     = clk_sel_i;
        end else if (acc_stop) begin
          state_d = ST_STOP;
          phase_d = PH_LOW;
          sel_d   = clk_sel_i;
        end else if (acc_wr || acc_rd) begin
          state_d     = ST_XFER;
          phase_d     = PH_LOW;
          sel_d       = clk_sel_i;
          ack_en_d    = ack_en_i;
          is_rd_d     = acc_rd;
          shift_d     = tx_data_i;
          rx_d        = '0;
          ack_stage_d = 1'b0;
          left_d      = (bc_q == '0) ? LEFT_W'(DATA_W) : {1'b0, bc_q};
        end
      end
      default: begin
        unique case (phase_q)
          PH_LOW: begin
            // SDA moves one cycle after SCL has fallen
            if (tmr_cnt == '0) sda_rel_d = low_sda;
            if (tmr_last) begin
              scl_rel_d = 1'b1;
              phase_d   = PH_HIGH;
            end
          end
          PH_HIGH: begin
            if ((state_q == ST_XFER) && (tmr_cnt == mid_cnt)) begin
              if (ack_stage_q)  ack_d = sda_i;
              else if (is_rd_q) rx_d  = {rx_q[DATA_W-2:0], sda_i};
            end
            if (tmr_last) begin
              if (state_q == ST_START) begin
                sda_rel_d = 1'b0;
                phase_d   = PH_HIGH2;
              end else if (state_q == ST_STOP) begin
                sda_rel_d = 1'b1;
                phase_d   = PH_HIGH2;
              end else begin
                scl_rel_d = 1'b0;
                phase_d   = PH_LOW;
                if (ack_stage_q) begin
                  state_d = ST_HOLD;
                  done_d  = 1'b1;
                end else begin
                  shift_d = shift_q << 1;
                  left_d  = left_q - LEFT_W'(1);
                  if (left_q == LEFT_W'(1)) begin
                    if (ack_en_q) begin
                      ack_stage_d = 1'b1;
                    end else begin
                      state_d = ST_HOLD;
                      done_d  = 1'b1;
                      ack_d   = 1'b1;
                    end
                  end
                end
              end
            end
          end
          default: begin
            if (tmr_last) begin
              if (state_q == ST_START) begin
                scl_rel_d = 1'b0;
                state_d   = ST_HOLD;
              end else begin
                state_d = ST_IDLE;
              end
              phase_d = PH_LOW;
            end
          end
        endcase
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q     <= ST_IDLE;
      phase_q     <= PH_LOW;
      scl_rel_q   <= 1'b1;
      sda_rel_q   <= 1'b1;
      shift_q     <= '0;
      rx_q        <= '0;
      left_q      <= '0;
      ack_stage_q <= 1'b0;
      is_rd_q     <= 1'b0;
      ack_en_q    <= 1'b0;
      sel_q       <= '0;
      bc_q        <= '0;
      ack_q       <= 1'b1;
      done_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      phase_q     <= phase_d;
      scl_rel_q   <= scl_rel_d;
      sda_rel_q   <= sda_rel_d;
      shift_q     <= shift_d;
      rx_q        <= rx_d;
      left_q      <= left_d;
      ack_stage_q <= ack_stage_d;
      is_rd_q     <= is_rd_d;
      ack_en_q    <= ack_en_d;
      sel_q       <= sel_d;
      bc_q        <= bc_d;
      ack_q       <= ack_d;
      done_q      <= done_d;
    end
  end

  assign scl_oe_o  = !scl_rel_q;
  assign sda_oe_o  = !sda_rel_q;
  assign busy_o    = run;
  assign done_o    = done_q;
  assign ack_o     = ack_q;
  assign rx_data_o = rx_q;
  assign bit_cnt_o = bc_q;

  // R3: data and acknowledge bits hold steady while SCL is released
  assert_sda_steady_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_XFER && scl_rel_q && $past(scl_rel_q)) |-> $stable(sda_rel_q));

  // R5: a reading master pulls SDA low through the acknowledge high phase
  assert_rd_ack_low_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_XFER && ack_stage_q && is_rd_q && scl_rel_q) |-> !sda_rel_q);

  // R6: no acknowledge step is entered when it was not enabled
  assert_no_ack_step_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_XFER && !ack_en_q) |-> !ack_stage_q);

  // R7: a start clears the bit-count setting
  assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    acc_start |=> (bc_q == '0));

  // R8: the idle bus has both lines released
  assert_idle_free_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_IDLE) |-> (scl_rel_q && sda_rel_q));

  // R9: done lasts a single cycle and leaves the bus held
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_q |-> (!$past(done_q) && state_q == ST_HOLD));

endmodule

// File: tb/tb_i2c_byte_master.sv
module tb_i2c_byte_master;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ack_en = 1'b0;
  logic [2:0] clk_sel = 3'd0;
  logic       bc_we = 1'b0;
  logic [2:0] bc_wdata = 3'd0;
  logic       start_s = 1'b0, stop_s = 1'b0, wr_s = 1'b0, rd_s = 1'b0;
  logic [7:0] tx_data = 8'd0;
  logic       scl_oe, sda_oe, busy, done, ack;
  logic [7:0] rx_data;
  logic [2:0] bit_cnt;

  logic slave_rel = 1'b1;
  logic scl_line, sda_line;
  assign scl_line = !scl_oe;
  assign sda_line = !sda_oe && slave_rel;

  always #4 clk = !clk;

  i2c_byte_master dut (
    .clk(clk), .rst_n(rst_n), .ack_en_i(ack_en), .clk_sel_i(clk_sel),
    .bc_we_i(bc_we), .bc_wdata_i(bc_wdata), .start_i(start_s), .stop_i(stop_s),
    .wr_i(wr_s), .rd_i(rd_s), .tx_data_i(tx_data), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy), .done_o(done),
    .ack_o(ack), .rx_data_o(rx_data), .bit_cnt_o(bit_cnt)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard item
  typedef struct {
    int        n;
    logic [15:0] bits;
    logic      ack;
    bit        is_rd;
    logic [7:0] rx;
    string     req;
  } exp_t;
  exp_t exp_q[$];

  // slave model: presents one bit per SCL pulse, advanced on SCL falls
  logic [15:0] slave_vec = 16'hFFFF;
  bit          slave_go = 1'b0;
  bit          go_seen = 1'b0;
  int          sidx = 0;
  logic        prev_scl_s = 1'b1;
  always @(negedge clk) begin
    if (slave_go != go_seen) begin
      go_seen   = slave_go;
      sidx      = 0;
      slave_rel = slave_vec[0];
    end else if (prev_scl_s && !scl_line) begin
      sidx++;
      slave_rel = (sidx < 16) ? slave_vec[sidx] : 1'b1;
    end
    prev_scl_s = scl_line;
  end

  // monitor: bus decoding, timing and scoreboard comparison
  logic        prev_scl = 1'b1, prev_sda = 1'b1;
  logic [15:0] cap_bits = '0;
  int          cap_n = 0;
  int          low_cnt = 0, high_cnt = 0, last_low = 0, last_high = 0;
  int          start_seen = 0, stop_seen = 0, rise_total = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!prev_scl && scl_line) begin
        if (cap_n < 16) cap_bits[cap_n] = sda_line;
        cap_n++;
        rise_total++;
        last_low = low_cnt;
        high_cnt = 1;
      end else if (prev_scl && !scl_line) begin
        last_high = high_cnt;
        low_cnt = 1;
      end else if (scl_line) high_cnt++;
      else low_cnt++;
      if (prev_scl && scl_line && prev_sda && !sda_line) begin
        start_seen++;
        cap_n = 0;
      end
      if (prev_scl && scl_line && !prev_sda && sda_line) stop_seen++;
      if (done) begin
        if (exp_q.size() == 0) begin
          chk("R9 unexpected done pulse", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk({e.req, " SCL pulse count"}, cap_n, e.n);
          for (int i = 0; i < e.n; i++)
            chk({e.req, " SDA bit on bus"}, int'(cap_bits[i]), int'(e.bits[i]));
          chk({e.req, " ack_o"}, int'(ack), int'(e.ack));
          if (e.is_rd) chk({e.req, " rx_data_o"}, int'(rx_data), int'(e.rx));
        end
        cap_n = 0;
      end
    end
    prev_scl = scl_line;
    prev_sda = sda_line;
  end

  task automatic wait_free();
    int guard = 0;
    @(negedge clk);
    @(negedge clk);
    while (busy && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  task automatic set_bc(input logic [2:0] v);
    @(negedge clk);
    bc_wdata = v;
    bc_we = 1'b1;
    @(negedge clk);
    bc_we = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk);
    start_s = 1'b1;
    @(negedge clk);
    start_s = 1'b0;
    wait_free();
  endtask

  task automatic do_stop();
    @(negedge clk);
    stop_s = 1'b1;
    @(negedge clk);
    stop_s = 1'b0;
    wait_free();
  endtask

  // driver: computes expected bus bits and status, then issues the command
  task automatic do_xfer(input bit rdop, input logic [7:0] data, input logic [2:0] bc,
                         input bit aen, input logic slave_ack, input bit poke,
                         input string req);
    exp_t e;
    int   k;
    logic [15:0] sv;
    k  = (bc == 3'd0) ? 8 : int'(bc);
    sv = 16'hFFFF;
    e.n = k + (aen ? 1 : 0);
    e.bits = '0;
    e.is_rd = rdop;
    e.rx = '0;
    e.req = req;
    for (int i = 0; i < k; i++) begin
      if (rdop) begin
        e.bits[i] = data[k-1-i];
        sv[i]     = data[k-1-i];
        e.rx[k-1-i] = data[k-1-i];
      end else begin
        e.bits[i] = data[7-i];
      end
    end
    if (aen) begin
      if (rdop) begin
        e.bits[k] = 1'b0;
        e.ack     = 1'b0;
      end else begin
        sv[k]     = slave_ack;
        e.bits[k] = slave_ack;
        e.ack     = slave_ack;
      end
    end else begin
      e.ack = 1'b1;
    end
    set_bc(bc);
    @(negedge clk);
    ack_en    = aen;
    tx_data   = rdop ? 8'h00 : data;
    slave_vec = sv;
    slave_go  = !slave_go;
    exp_q.push_back(e);
    @(negedge clk);
    if (rdop) rd_s = 1'b1;
    else      wr_s = 1'b1;
    @(negedge clk);
    rd_s = 1'b0;
    wr_s = 1'b0;
    if (poke) begin
      repeat (50) @(negedge clk);
      start_s = 1'b1; stop_s = 1'b1; wr_s = 1'b1; rd_s = 1'b1;
      @(negedge clk);
      start_s = 1'b0; stop_s = 1'b0; wr_s = 1'b0; rd_s = 1'b0;
    end
    wait_free();
  endtask

  initial begin
    int s0, r0;
    repeat (3) @(negedge clk);
    // R1: outputs while reset is held
    chk("R1 scl_oe in reset", int'(scl_oe), 0);
    chk("R1 sda_oe in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 scl_oe after reset", int'(scl_oe), 0);
    chk("R1 sda_oe after reset", int'(sda_oe), 0);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 ack after reset", int'(ack), 1);
    chk("R1 bit count after reset", int'(bit_cnt), 0);

    // R7: bit count keeps a written value, start clears it
    set_bc(3'd5);
    @(negedge clk);
    chk("R7 bit count written", int'(bit_cnt), 5);
    clk_sel = 3'd0;
    do_start();
    chk("R7 start condition seen", start_seen, 1);
    chk("R7 bit count cleared by start", int'(bit_cnt), 0);
    chk("R7 SCL held low after start", int'(scl_oe), 1);

    // R3 R4 R2: full byte write, acknowledged, rate code 0
    do_xfer(1'b0, 8'hA5, 3'd0, 1'b1, 1'b0, 1'b0, "R3 R4 write A5 ack");
    chk("R2 low time code 0", last_low, 16);
    chk("R2 high time code 0", last_high, 24);

    // R3 R4: 3-bit write, slave does not acknowledge
    do_xfer(1'b0, 8'hC0, 3'd3, 1'b1, 1'b1, 1'b0, "R3 R4 write 3 bits nack");
    chk("R7 bit count kept across transfers", int'(bit_cnt), 3);

    // R5: full read with master acknowledge
    do_xfer(1'b1, 8'h3C, 3'd0, 1'b1, 1'b1, 1'b0, "R5 read 8 bits ack");

    // R5 R6: 4-bit read without acknowledge pulse
    do_xfer(1'b1, 8'h0B, 3'd4, 1'b0, 1'b1, 1'b0, "R5 R6 read 4 bits no ack");

    // R2 R6: rate code 2, write without acknowledge
    clk_sel = 3'd2;
    do_xfer(1'b0, 8'h5A, 3'd0, 1'b0, 1'b1, 1'b0, "R6 write no ack");
    chk("R2 low time code 2", last_low, 64);
    chk("R2 high time code 2", last_high, 72);

    // R2: reserved code 7 behaves as n = 11
    clk_sel = 3'd7;
    do_xfer(1'b0, 8'h80, 3'd1, 1'b1, 1'b0, 1'b0, "R3 write 1 bit code 7");
    chk("R2 low time code 7", last_low, 1024);
    chk("R2 high time code 7", last_high, 1032);

    // R10: strobes during a busy transfer are ignored
    clk_sel = 3'd1;
    s0 = start_seen;
    r0 = stop_seen;
    do_xfer(1'b0, 8'hFF, 3'd0, 1'b1, 1'b0, 1'b1, "R10 write with busy strobes");
    chk("R10 no start while busy", start_seen, s0);
    chk("R10 no stop while busy", stop_seen, r0);

    // R7: repeated start from a held bus
    set_bc(3'd6);
    do_start();
    chk("R7 repeated start seen", start_seen, s0 + 1);
    chk("R7 bit count cleared by repeated start", int'(bit_cnt), 0);

    // R8: stop condition
    do_stop();
    chk("R8 stop condition seen", stop_seen, r0 + 1);
    chk("R8 SCL released after stop", int'(scl_oe), 0);
    chk("R8 SDA released after stop", int'(sda_oe), 0);
    chk("R8 busy low after stop", int'(busy), 0);

    // R10: write, read and stop on an idle bus are ignored
    r0 = rise_total;
    @(negedge clk);
    wr_s = 1'b1;
    @(negedge clk);
    wr_s = 1'b0;
    rd_s = 1'b1;
    @(negedge clk);
    rd_s = 1'b0;
    stop_s = 1'b1;
    @(negedge clk);
    stop_s = 1'b0;
    repeat (200) @(negedge clk);
    chk("R10 no SCL pulse on idle bus", rise_total, r0);
    chk("R10 busy stays low on idle bus", int'(busy), 0);
    chk("R9 all expected transfers done", exp_q.size(), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule